// File: doc/BRIEF.md
# Runtime-Rate CIC Decimator with Gain Correction

This block lowers the sample rate of a complex baseband stream by an integer factor chosen while it runs. Signed I and Q samples enter on a valid/ready stream. Both lanes pass in lockstep through a fourth-order cascaded integrator-comb decimator with a differential delay of one. Each decimated pair is then multiplied by a signed gain word with 15 fractional bits. The result is shifted right to remove the CIC bit growth and clipped to the output width.

Software sets the rate with a 16-bit decimation word. The low byte selects the CIC rate R, and the high byte is a halfband-stage count that the block only passes to its `hb_count` output for a later filter cascade. A separate write loads the gain word. A rate of one skips the integrators and combs, so only the gain stage acts. Rates above the `RMAX` parameter are clamped to `RMAX`.

One state machine sequences both lanes:
- **ST_TAKE** accepts input pairs. It moves to **ST_COMB** when a group of R pairs completes, moves to **ST_GAIN** at once when R is 1, and otherwise stays in ST_TAKE.
- **ST_COMB** runs the comb chain once and moves to ST_GAIN.
- **ST_GAIN** registers the scaled, clipped pair and moves to **ST_SEND**.
- **ST_SEND** presents the pair and returns to ST_TAKE when it is taken.

A decimation-word write returns the machine to ST_TAKE from any state.

Top module: `cicd_decim_scaler`

## Requirements
- R1: The decimation word uses bits [7:0] for the rate R and bits [15:8] for the halfband count. The count appears on `hb_count` in the cycle after the write.
- R2: A rate field of 0 behaves exactly like R = 1.
- R3: For R > 1, one output pair is produced for every R accepted input pairs, and I and Q are processed together. Each integrator k updates on every accepted input as a_k = a_k + a_(k-1), using the new value of a_(k-1), with a_0 equal to the input. On the R-th input, the new a_4 is captured as v. v passes through four combs, each computing c = v - d and then storing d = v from its own input.
- R4: The output is floor(v * S / 2^(15+s)), where S is the signed gain word and s = ceil(log2(R^4)). For R = 1, v is the input sample and s = 0.
- R5: Results outside the signed output range clip to -2^(OUT_W-1) or 2^(OUT_W-1)-1 instead of wrapping.
- R6: After reset, R = 1, `hb_count` = 0 and S = 2^15 (unity gain). `out_valid` is 0 and `in_ready` is 1.
- R7: With R = 1, the output is valid after the second clock edge following acceptance. For R > 1, the output is valid after the third edge following the group's last accepted input.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and the output data hold. `in_ready` stays low from the edge that completes a group until the pair is taken.
- R9: A decimation-word write clears the integrators, combs and group counter, and discards any pair being processed or waiting. `in_ready` is low in the cycle of the write.
- R10: A gain-word write applies to pairs scaled after it, and does not clear the filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_we | input | 1 | Decimation-word write strobe |
| dec_word | input | 16 | Rate [7:0], halfband count [15:8] |
| scl_we | input | 1 | Gain-word write strobe |
| scl_word | input | SCALE_W | Signed gain, 2^15 = unity |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| in_i | input | IN_W | Input in-phase sample |
| in_q | input | IN_W | Input quadrature sample |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts output pair |
| out_i | output | OUT_W | Output in-phase sample |
| out_q | output | OUT_W | Output quadrature sample |
| hb_count | output | 8 | Halfband-stage count for the next cascade |

## Verification
Two events can land in the same cycle: a decimation-word write, and an input pair offered while the machine is mid-group. The bench provokes this by presenting a pair together with the write strobe, half-way through a rate-2 group.

The bench judges the case in three steps:
- `in_ready` must be low in that cycle.
- The held pair must then be accepted under the new rate-1 setting.
- Its output must equal the gain applied to that sample alone, with nothing carried over from the old group.

A second overlap, a write that arrives while a result waits under back-pressure, must drop that result.

// File: rtl/cicd_pkg.sv
package cicd_pkg;

    typedef enum logic [1:0] {
        ST_TAKE,
        ST_COMB,
        ST_GAIN,
        ST_SEND
    } cicd_state_e;

    localparam int STAGES = 4;
    localparam int FRAC   = 15;

    // ceil(log2(r^4)); r = 1 gives 0
    function automatic logic [5:0] growth_shift(input logic [7:0] r);
        logic [31:0] r4;
        logic [5:0]  n;
        r4 = 32'(r) * 32'(r) * 32'(r) * 32'(r);
        n  = '0;
        for (int b = 0; b < 32; b++) begin
            if ((33'd1 << b) < {1'b0, r4}) n = 6'(b + 1);
        end
        return n;
    endfunction

endpackage

// File: rtl/cicd_integ.sv
module cicd_integ
    import cicd_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [ACC_W-1:0] y
);

    logic signed [ACC_W-1:0] acc_q [STAGES];
    logic signed [ACC_W-1:0] sum   [STAGES];

    always_comb begin
        sum[0] = acc_q[0] + ACC_W'(x);
        for (int s = 1; s < STAGES; s++) begin
            sum[s] = acc_q[s] + sum[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) acc_q[s] <= '0;
        end else if (clr) begin
            for (int s = 0; s < STAGES; s++) acc_q[s] <= '0;
        end else if (en) begin
            for (int s = 0; s < STAGES; s++) acc_q[s] <= sum[s];
        end
    end

    assign y = sum[STAGES-1];

endmodule

// File: rtl/cicd_comb.sv
module cicd_comb
    import cicd_pkg::*;
#(
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] v,
    output logic signed [ACC_W-1:0] y
);

    logic signed [ACC_W-1:0] dly_q [STAGES];
    logic signed [ACC_W-1:0] tap   [STAGES+1];

    always_comb begin
        tap[0] = v;
        for (int s = 0; s < STAGES; s++) begin
            tap[s+1] = tap[s] - dly_q[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) dly_q[s] <= '0;
        end else if (clr) begin
            for (int s = 0; s < STAGES; s++) dly_q[s] <= '0;
        end else if (en) begin
            for (int s = 0; s < STAGES; s++) dly_q[s] <= tap[s];
        end
    end

    assign y = tap[STAGES];

endmodule

// File: rtl/cicd_gain.sv
module cicd_gain
    import cicd_pkg::*;
#(
    parameter int ACC_W   = 48,
    parameter int SCALE_W = 18,
    parameter int OUT_W   = 16
) (
    input  logic signed [ACC_W-1:0]   v,
    input  logic signed [SCALE_W-1:0] scale,
    input  logic        [5:0]         shift,
    output logic signed [OUT_W-1:0]   y
);

    localparam int P_W = ACC_W + SCALE_W;
    localparam logic signed [P_W-1:0] HI =
        {{(P_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [P_W-1:0] LO =
        {{(P_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] shifted;
    logic        [6:0]     shamt;

    always_comb begin
        shamt   = 7'(FRAC) + 7'(shift);
        prod    = P_W'(v) * P_W'(scale);
        shifted = prod >>> shamt;
        if (shifted > HI)      y = HI[OUT_W-1:0];
        else if (shifted < LO) y = LO[OUT_W-1:0];
        else                   y = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/cicd_decim_scaler.sv
module cicd_decim_scaler
    import cicd_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int OUT_W   = 16,
    parameter int SCALE_W = 18,
    parameter int RMAX    = 255
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dec_we,
    input  logic [15:0]               dec_word,
    input  logic                      scl_we,
    input  logic signed [SCALE_W-1:0] scl_word,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [IN_W-1:0]    in_i,
    input  logic signed [IN_W-1:0]    in_q,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic signed [OUT_W-1:0]   out_i,
    output logic signed [OUT_W-1:0]   out_q,
    output logic [7:0]                hb_count
);

    localparam int LANES = 2;
    localparam int ACC_W = IN_W + STAGES * $clog2(RMAX);
    localparam logic [7:0] RTOP = 8'(RMAX);
    localparam logic signed [SCALE_W-1:0] UNITY = SCALE_W'(1 << FRAC);

    cicd_state_e state_q, state_d;

    logic [7:0]                rate_q, hb_q, phase_q, rate_new;
    logic [5:0]                shift_q;
    logic signed [SCALE_W-1:0] scale_q;
    logic                      take, bypass, last, integ_en, comb_en, gain_ld;

    logic signed [IN_W-1:0]  lane_in  [LANES];
    logic signed [OUT_W-1:0] lane_out [LANES];

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;
    assign out_i      = lane_out[0];
    assign out_q      = lane_out[1];
    assign hb_count   = hb_q;

    // rate decode: 0 acts as 1, above RMAX clamps
    always_comb begin
        if (dec_word[7:0] == 8'd0)       rate_new = 8'd1;
        else if (dec_word[7:0] > RTOP)   rate_new = RTOP;
        else                             rate_new = dec_word[7:0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TAKE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TAKE: begin
                if (take) begin
                    if (bypass)    state_d = ST_GAIN;
                    else if (last) state_d = ST_COMB;
                end
            end
            ST_COMB: state_d = ST_GAIN;
            ST_GAIN: state_d = ST_SEND;
            ST_SEND: if (out_ready) state_d = ST_TAKE;
            default: state_d = ST_TAKE;
        endcase
        if (dec_we) state_d = ST_TAKE;
    end

    // state outputs
    always_comb begin
        in_ready  = (state_q == ST_TAKE) && !dec_we;
        out_valid = (state_q == ST_SEND);
        take      = in_valid && in_ready;
        bypass    = (rate_q == 8'd1);
        last      = (phase_q == rate_q - 8'd1);
        integ_en  = take && !bypass;
        comb_en   = (state_q == ST_COMB) && !dec_we;
        gain_ld   = (state_q == ST_GAIN) && !dec_we;
    end

    // configuration and group counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q  <= 8'd1;
            hb_q    <= '0;
            shift_q <= '0;
            phase_q <= '0;
            scale_q <= UNITY;
        end else begin
            if (dec_we) begin
                rate_q  <= rate_new;
                hb_q    <= dec_word[15:8];
                shift_q <= growth_shift(rate_new);
                phase_q <= '0;
            end else if (integ_en) begin
                phase_q <= last ? 8'd0 : phase_q + 8'd1;
            end
            if (scl_we) scale_q <= scl_word;
        end
    end

    // per-lane datapath
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [ACC_W-1:0] integ_y, comb_y, dec_q, res_q;
        logic signed [OUT_W-1:0] gain_y, o_q;

        cicd_integ #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
            .clk(clk), .rst_n(rst_n), .clr(dec_we), .en(integ_en),
            .x(lane_in[l]), .y(integ_y)
        );

        cicd_comb #(.ACC_W(ACC_W)) u_comb (
            .clk(clk), .rst_n(rst_n), .clr(dec_we), .en(comb_en),
            .v(dec_q), .y(comb_y)
        );

        cicd_gain #(.ACC_W(ACC_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)) u_gain (
            .v(res_q), .scale(scale_q), .shift(shift_q), .y(gain_y)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dec_q <= '0;
                res_q <= '0;
                o_q   <= '0;
            end else begin
                if (integ_en && last) dec_q <= integ_y;
                if (take && bypass)   res_q <= ACC_W'(lane_in[l]);
                if (comb_en)          res_q <= comb_y;
                if (gain_ld)          o_q   <= gain_y;
            end
        end

        assign lane_out[l] = o_q;
    end

endmodule

// File: rtl/cicd_checker.sv
module cicd_checker #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_we,
    input logic [7:0]       hb_word,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q,
    input logic [7:0]       hb_count,
    input logic [7:0]       rate_q
);

    AST_HB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_we |=> hb_count == $past(hb_word)); // R1

    AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !dec_we |=>
            out_valid && $stable(out_i) && $stable(out_q)); // R8

    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8

    AST_CFG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_we |-> !in_ready); // R9

    AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        dec_we |=> !out_valid); // R9

    AST_BYPASS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q == 8'd1) && in_valid && in_ready |=> !in_ready && !out_valid); // R7

endmodule

bind cicd_decim_scaler cicd_checker #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_we(dec_we), .hb_word(dec_word[15:8]),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .hb_count(hb_count), .rate_q(rate_q)
);

// File: tb/cicd_decim_scaler_test.sv
module cicd_decim_scaler_test;

    localparam int IN_W = 16, OUT_W = 16, SCALE_W = 18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dec_we = 1'b0, scl_we = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
    logic [15:0] dec_word = '0;
    logic signed [SCALE_W-1:0] scl_word = '0;
    logic signed [IN_W-1:0] in_i = '0, in_q = '0;
    logic in_ready, out_valid;
    logic signed [OUT_W-1:0] out_i, out_q;
    logic [7:0] hb_count;

    always #10ns clk = ~clk;

    cicd_decim_scaler #(.IN_W(IN_W), .OUT_W(OUT_W), .SCALE_W(SCALE_W), .RMAX(255)) uut (
        .clk(clk), .rst_n(rst_n), .dec_we(dec_we), .dec_word(dec_word),
        .scl_we(scl_we), .scl_word(scl_word), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_ready(out_ready),
        .out_i(out_i), .out_q(out_q), .hb_count(hb_count)
    );

    typedef struct packed {
        int rate; int hb; int scale; int i0; int di; int q0; int dq; int nout; int stall;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1, 0, 32768,   100,    37,   -50,  -11, 6, 0},
        '{0, 3, 16384,  -301,     5,    77,    3, 5, 0},
        '{2, 1, 32768,  1000,     0, -1000,    0, 6, 1},
        '{3, 0, 52000,   200,    13,    -7,   29, 6, 0},
        '{4, 2, 40000,  -500,    17,  3000,   -9, 5, 1},
        '{8, 5, 32768,  2000,    -3, -1500,    7, 4, 0},
        '{1, 7, 131071, 20000, -10000, -20000, 10000, 5, 0}
    };

    int n_chk = 0, n_bad = 0, n_got = 0, cyc = 0;
    bit last_take;

    longint m_int [2][4];
    longint m_dly [2][4];
    longint m_rate = 1, m_shift = 0, m_scale = 32768, m_phase = 0;
    longint qi [$];
    longint qq [$];

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint shift_of(input longint r);
        longint r4 = r * r * r * r;
        longint n = 0;
        while ((longint'(1) << n) < r4) n++;
        return n;
    endfunction

    function automatic longint gain(input longint v);
        longint p = (v * m_scale) >>> (15 + m_shift);
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return p;
    endfunction

    task automatic model_clear(input logic [15:0] w);
        m_rate = (w[7:0] == 0) ? 1 : longint'(w[7:0]);
        m_shift = shift_of(m_rate);
        m_phase = 0;
        for (int l = 0; l < 2; l++)
            for (int s = 0; s < 4; s++) begin m_int[l][s] = 0; m_dly[l][s] = 0; end
        qi.delete(); qq.delete();
    endtask

    task automatic model_accept(input longint xi, input longint xq);
        longint x [2];
        longint y [2];
        x[0] = xi; x[1] = xq;
        if (m_rate == 1) begin
            qi.push_back(gain(xi)); qq.push_back(gain(xq));
        end else begin
            for (int l = 0; l < 2; l++) begin
                longint v = x[l];
                for (int s = 0; s < 4; s++) begin m_int[l][s] += v; v = m_int[l][s]; end
                y[l] = v;
            end
            if (m_phase == m_rate - 1) begin
                for (int l = 0; l < 2; l++) begin
                    for (int s = 0; s < 4; s++) begin
                        longint p = y[l];
                        y[l] = y[l] - m_dly[l][s];
                        m_dly[l][s] = p;
                    end
                end
                qi.push_back(gain(y[0])); qq.push_back(gain(y[1]));
                m_phase = 0;
            end else m_phase++;
        end
    endtask

    // one clock: observe handshakes just after drives settle, then wait to next negedge
    task automatic cycle();
        #1ns;
        last_take = 1'b0;
        if (out_valid && out_ready) begin
            n_got++;
            if (qi.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R3 unexpected output actual=%0d expected=none", out_i);
            end else begin
                chk("R3 R4 R5 lane I", longint'(out_i), qi.pop_front());
                chk("R3 R4 R5 lane Q", longint'(out_q), qq.pop_front());
            end
        end
        if (in_valid && in_ready) begin
            last_take = 1'b1;
            model_accept(longint'(in_i), longint'(in_q));
        end
        if (dec_we) model_clear(dec_word);
        if (scl_we) m_scale = longint'(scl_word);
        cyc++;
        @(negedge clk);
    endtask

    task automatic cfg(input int rate, input int hb, input int scale);
        in_valid = 1'b0;
        dec_word = 16'((hb << 8) | rate); dec_we = 1'b1;
        scl_word = SCALE_W'(scale); scl_we = 1'b1;
        cycle();
        dec_we = 1'b0; scl_we = 1'b0;
    endtask

    task automatic drain();
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (6) cycle();
        chk("R3 nothing left pending", qi.size(), 0);
    endtask

    task automatic send(input int xi, input int xq);
        int guard = 0;
        in_i = IN_W'(xi); in_q = IN_W'(xq); in_valid = 1'b1;
        last_take = 1'b0;
        while (!last_take && guard < 100) begin cycle(); guard++; end
        in_valid = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int got0, k, guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1ns;
        // R6 reset state
        chk("R6 out_valid", out_valid, 0);
        chk("R6 in_ready", in_ready, 1);
        chk("R6 hb_count", hb_count, 0);
        @(negedge clk);
        send(1234, -4321);
        drain();
        chk("R6 unity default passthrough seen", n_got, 1);

        // table walk
        foreach (VEC[e]) begin
            cfg(VEC[e].rate, VEC[e].hb, VEC[e].scale);
            chk("R1 hb_count field", hb_count, VEC[e].hb);
            got0 = n_got; k = 0; guard = 0;
            while (n_got - got0 < VEC[e].nout && guard < 3000) begin
                in_valid = 1'b1;
                in_i = IN_W'(VEC[e].i0 + VEC[e].di * k);
                in_q = IN_W'(VEC[e].q0 + VEC[e].dq * k);
                out_ready = (VEC[e].stall != 0) ? (cyc % 3 == 0) : 1'b1;
                cycle();
                if (last_take) k++;
                guard++;
            end
            chk("R3 output count per table entry", n_got - got0, VEC[e].nout);
            in_valid = 1'b0; out_ready = 1'b1;
            if (VEC[e].rate > 1)
                chk("R3 inputs per outputs", k / VEC[e].nout, VEC[e].rate);
        end
        drain();

        // R7 latency, bypass
        cfg(1, 0, 32768);
        in_i = 16'sd77; in_q = 16'sd5; in_valid = 1'b1;
        cycle(); in_valid = 1'b0;
        chk("R7 bypass not yet valid", out_valid, 0);
        cycle();
        chk("R7 bypass valid after second edge", out_valid, 1);
        drain();
        // R7 latency, decimated
        cfg(2, 0, 32768);
        send(10, 10);
        in_i = 16'sd10; in_q = 16'sd10; in_valid = 1'b1;
        cycle(); in_valid = 1'b0;
        chk("R7 decim not valid after edge 1", out_valid, 0);
        cycle();
        chk("R7 decim not valid after edge 2", out_valid, 0);
        cycle();
        chk("R7 decim valid after edge 3", out_valid, 1);
        drain();

        // R8 back-pressure
        cfg(1, 0, 32768);
        out_ready = 1'b0;
        send(500, -600);
        cycle();
        chk("R8 output presented", out_valid, 1);
        in_i = 16'sd9; in_q = 16'sd9; in_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            cycle();
            chk("R8 valid held", out_valid, 1);
            chk("R8 data held", longint'(out_i), 500);
            chk("R8 no input while busy", in_ready, 0);
        end
        out_ready = 1'b1;
        cycle();
        guard = 0;
        while (in_valid && guard < 10) begin
            cycle(); if (last_take) in_valid = 1'b0; guard++;
        end
        drain();

        // R9 clear mid-group
        cfg(4, 0, 32768);
        send(1000, 1000); send(2000, -2000);
        cfg(4, 0, 32768);
        for (int j = 0; j < 4; j++) send(300 + j, -300 - j);
        drain();
        // R9 discard waiting output
        cfg(1, 0, 32768);
        out_ready = 1'b0;
        send(700, 700);
        cycle();
        chk("R9 output waiting", out_valid, 1);
        dec_word = 16'h0001; dec_we = 1'b1;
        cycle(); dec_we = 1'b0;
        chk("R9 waiting output dropped", out_valid, 0);
        got0 = n_got;
        drain();
        chk("R9 no output after drop", n_got - got0, 0);

        // coincidence: write with offered input mid-group
        cfg(2, 0, 32768);
        send(111, 222);
        in_i = 16'sd4000; in_q = -16'sd4000; in_valid = 1'b1;
        dec_word = 16'h0001; dec_we = 1'b1;
        #1ns;
        chk("R9 in_ready low during write", in_ready, 0);
        cycle(); dec_we = 1'b0;
        got0 = n_got;
        guard = 0;
        while (in_valid && guard < 10) begin
            cycle(); if (last_take) in_valid = 1'b0; guard++;
        end
        drain();
        chk("R2 R9 held pair produced one output", n_got - got0, 1);

        // R10 gain write keeps state
        cfg(2, 0, 32768);
        send(800, -800);
        scl_word = SCALE_W'(20000); scl_we = 1'b1;
        cycle(); scl_we = 1'b0;
        send(900, -900);
        send(100, 100); send(150, 150);
        drain();
        chk("R10 outputs after gain write", qi.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule